// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides whether an incoming Ethernet frame is kept or thrown away, looking only at the start of the frame. Header bytes arrive one per cycle on a byte stream marked with start-of-frame and end-of-frame flags. The block keeps the six destination bytes, the 16-bit type field and the 12-bit VLAN identifier that follows it. A fixed number of cycles after the sixteenth byte, or after the final byte of a shorter frame, it produces one decision pulse that carries an accept flag.

The decision is made in a fixed order. First comes an optional VLAN-membership veto. When that does not drop the frame, the frame is accepted if any of these holds: unicast promiscuous mode is on; the destination is a group address and multicast promiscuous mode is on; the destination is the broadcast address and broadcast acceptance is on; it hits one of the exact-match address entries; or it hits the multicast hash table. Software loads the exact-match entries through one write port. It loads the two 4096-bit bitmaps, one for the hash and one for VLAN membership, through a second port, one 32-bit word at a time.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset `dec_valid` and `dec_accept` are low, all exact-match entries are invalid and both bitmaps are all zero, so with every mode off an ordinary unicast frame is dropped.
- R2: `dec_valid` is a one-cycle pulse. It is sampled high two clock edges after the edge that samples frame byte 15 (bytes are numbered from 0). Bytes after byte 15 do not cause another pulse, and `dec_accept` is low whenever `dec_valid` is low.
- R3: When VLAN filtering is on, the frame has 16 or more bytes and {byte12, byte13} equals `cfg_tag_type`, the VLAN ID is {byte14[3:0], byte15}. If bit ID[4:0] of VLAN bitmap word ID[11:5] is clear, the frame is dropped, even in any promiscuous mode.
- R4: If that VLAN bitmap bit is set, or the type field does not match, or VLAN filtering is off, the frame goes on to the address rules unchanged.
- R5: With unicast promiscuous mode on, every frame that passes the VLAN check is accepted.
- R6: With multicast promiscuous mode on, a frame whose byte 0 has bit 0 set is accepted. Bit 0 clear gives no acceptance from this rule.
- R7: With broadcast accept on, a destination of six 0xFF bytes is accepted. Any other destination, or the same destination with the enable off, gets no acceptance from this rule.
- R8: Each of the `N_EXACT` entries holds a 48-bit address and a valid flag. Frame byte k is compared with entry bits [8k+7:8k], and a full match on any valid entry accepts the frame. The highest-numbered entry also works.
- R9: An entry written with its valid flag clear never accepts a frame, even when its address matches.
- R10: Otherwise a 12-bit hash is taken from the 16-bit value {byte5, byte4}, shifted right by 4, 3, 2 or 0 for `cfg_hash_sel` values 0, 1, 2 and 3. The frame is accepted if bit hash[4:0] of hash bitmap word hash[11:5] is set, and dropped if it is clear.
- R11: A frame whose end-of-frame flag comes on byte n with n < 15 is decided two edges after that byte. It skips the VLAN check, and destination bytes it never delivered read as zero.
- R12: A bitmap write with `tbl_sel` = 0 loads hash word `tbl_idx`, and with `tbl_sel` = 1 loads VLAN word `tbl_idx`. A write to one bitmap has no effect on decisions that use the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_ucast_promisc | input | 1 | Accept every frame that passes the VLAN check |
| cfg_mcast_promisc | input | 1 | Accept group-addressed frames |
| cfg_bcast_en | input | 1 | Accept the broadcast destination |
| cfg_vlan_filt_en | input | 1 | Enable the VLAN-membership veto |
| cfg_tag_type | input | 16 | Type value that marks a tagged frame |
| cfg_hash_sel | input | 2 | Selects the hash bit window |
| ent_we | input | 1 | Write strobe for an exact-match entry |
| ent_idx | input | $clog2(N_EXACT) | Entry number to write |
| ent_mac | input | 48 | Entry address, byte 0 in bits [7:0] |
| ent_valid | input | 1 | Valid flag written with the entry |
| tbl_we | input | 1 | Write strobe for a bitmap word |
| tbl_sel | input | 1 | 0 selects the hash bitmap, 1 the VLAN bitmap |
| tbl_idx | input | $clog2(TBL_WORDS) | Bitmap word number |
| tbl_wdata | input | WORD_W | Bitmap word value |
| hdr_valid | input | 1 | A header byte is present |
| hdr_first | input | 1 | This byte is byte 0 of a frame |
| hdr_last | input | 1 | This byte is the final byte of a frame |
| hdr_byte | input | 8 | Header byte |
| dec_valid | output | 1 | Decision pulse |
| dec_accept | output | 1 | Frame accepted, qualified by dec_valid |

## Verification
Every acceptance rule is tried with a pattern that should fire it and a near miss that should not. These pairs are a group bit against a unicast byte 0, six 0xFF bytes against one 0xFE byte, and an entry address in the right byte order against the reversed order. Each pair shows whether the rule is really keyed on the field the requirement names. The hash is tried with one destination under all four window selections while only one bitmap bit is set, so a wrong shift cannot pass. The VLAN veto is run with promiscuous mode on and the membership bit clear, then set, then with the filter off, then with a different type value. Short frames with a matching type show that the veto is skipped and that the decision comes early.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
   localparam int unsigned MAC_BYTES = 6;
   localparam int unsigned HASH_W    = 12;

   // 12-bit hash window taken from {byte5, byte4}
   function automatic logic [HASH_W-1:0] hash_window(input logic [15:0] pair,
                                                     input logic [1:0]  sel);
      logic [HASH_W-1:0] h;
      case (sel)
         2'd0:    h = pair[15:4];
         2'd1:    h = pair[14:3];
         2'd2:    h = pair[13:2];
         default: h = pair[11:0];
      endcase
      return h;
   endfunction
endpackage

// File: rtl/rxf_hdr_capture.sv
module rxf_hdr_capture
   import rxf_pkg::*;
#(
   parameter int unsigned HDR_BYTES = 16,
   parameter int unsigned TAG_POS   = 12
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic                    in_first,
   input  logic                    in_last,
   input  logic [7:0]              in_byte,
   output logic [8*MAC_BYTES-1:0]  dest,
   output logic [15:0]             ethtype,
   output logic [11:0]             vlan_id,
   output logic                    eval_go,
   output logic                    eval_full
);
   localparam int unsigned CNT_W = $clog2(HDR_BYTES + 1);

   initial begin
      hdr_len_chk: assert (TAG_POS + 4 == HDR_BYTES && TAG_POS >= MAC_BYTES)
         else $error("rxf_hdr_capture: tag bytes must close the header");
   end

   logic [CNT_W-1:0]       cnt;
   logic                   done;
   logic [CNT_W-1:0]       idx;
   logic                   take;
   logic                   fin;
   logic [8*MAC_BYTES-1:0] dest_n;
   logic [15:0]            type_n;
   logic [11:0]            vid_n;

   assign idx  = in_first ? '0 : cnt;
   assign take = in_valid && (in_first || !done);
   assign fin  = take && ((idx == CNT_W'(HDR_BYTES - 1)) || in_last);

   always_comb begin
      dest_n = dest;
      type_n = ethtype;
      vid_n  = vlan_id;
      if (take) begin
         if (in_first) begin
            dest_n = '0;
            type_n = '0;
            vid_n  = '0;
         end
         for (int i = 0; i < int'(MAC_BYTES); i++) begin
            if (idx == CNT_W'(i)) dest_n[8*i +: 8] = in_byte;
         end
         if (idx == CNT_W'(TAG_POS))     type_n[15:8] = in_byte;
         if (idx == CNT_W'(TAG_POS + 1)) type_n[7:0]  = in_byte;
         if (idx == CNT_W'(TAG_POS + 2)) vid_n[11:8]  = in_byte[3:0];
         if (idx == CNT_W'(TAG_POS + 3)) vid_n[7:0]   = in_byte;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         done      <= 1'b0;
         dest      <= '0;
         ethtype   <= '0;
         vlan_id   <= '0;
         eval_go   <= 1'b0;
         eval_full <= 1'b0;
      end else begin
         dest      <= dest_n;
         ethtype   <= type_n;
         vlan_id   <= vid_n;
         eval_go   <= fin;
         eval_full <= fin && (idx == CNT_W'(HDR_BYTES - 1));
         if (take) begin
            cnt  <= idx + 1'b1;
            done <= fin;
         end
      end
   end

   // R2
   go_needs_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !eval_go);
endmodule

// File: rtl/rxf_bit_table.sv
module rxf_bit_table #(
   parameter int unsigned WORDS  = 128,
   parameter int unsigned WORD_W = 32
)(
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                we,
   input  logic [$clog2(WORDS)-1:0]            widx,
   input  logic [WORD_W-1:0]                   wdata,
   input  logic [$clog2(WORDS*WORD_W)-1:0]     lk_idx,
   output logic                                lk_bit
);
   localparam int unsigned BIT_W = $clog2(WORD_W);
   localparam int unsigned IDX_W = $clog2(WORDS * WORD_W);

   initial begin
      tbl_pow2_chk: assert ((1 << BIT_W) == WORD_W && (1 << (IDX_W - BIT_W)) == WORDS)
         else $error("rxf_bit_table: sizes must be powers of two");
   end

   logic [WORD_W-1:0] mem [WORDS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < int'(WORDS); w++) mem[w] <= '0;
      end else if (we) begin
         mem[widx] <= wdata;
      end
   end

   assign lk_bit = mem[lk_idx[IDX_W-1:BIT_W]][lk_idx[BIT_W-1:0]];

   // R12
   tbl_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> mem[$past(widx)] == $past(wdata));
endmodule

// File: rtl/rxf_exact_cam.sv
module rxf_exact_cam #(
   parameter int unsigned ENTRIES = 16,
   parameter int unsigned ADDR_W  = 48
)(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we,
   input  logic [$clog2(ENTRIES)-1:0] widx,
   input  logic [ADDR_W-1:0]          waddr,
   input  logic                       wvalid,
   input  logic [ADDR_W-1:0]          dest,
   output logic                       hit
);
   logic [ENTRIES-1:0] ent_v;
   logic [ENTRIES-1:0] match;

   for (genvar e = 0; e < int'(ENTRIES); e++) begin : g_ent
      logic [ADDR_W-1:0] ent_a;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent_a    <= '0;
            ent_v[e] <= 1'b0;
         end else if (we && widx == $clog2(ENTRIES)'(e)) begin
            ent_a    <= waddr;
            ent_v[e] <= wvalid;
         end
      end
      assign match[e] = ent_v[e] && (ent_a == dest);
   end

   assign hit = |match;

   // R9
   invalid_never_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !wvalid) |=> !match[$past(widx)]);
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
   import rxf_pkg::*;
#(
   parameter int unsigned N_EXACT   = 16,
   parameter int unsigned TBL_WORDS = 128,
   parameter int unsigned WORD_W    = 32,
   parameter int unsigned HDR_BYTES = 16
)(
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cfg_ucast_promisc,
   input  logic                         cfg_mcast_promisc,
   input  logic                         cfg_bcast_en,
   input  logic                         cfg_vlan_filt_en,
   input  logic [15:0]                  cfg_tag_type,
   input  logic [1:0]                   cfg_hash_sel,
   input  logic                         ent_we,
   input  logic [$clog2(N_EXACT)-1:0]   ent_idx,
   input  logic [47:0]                  ent_mac,
   input  logic                         ent_valid,
   input  logic                         tbl_we,
   input  logic                         tbl_sel,
   input  logic [$clog2(TBL_WORDS)-1:0] tbl_idx,
   input  logic [WORD_W-1:0]            tbl_wdata,
   input  logic                         hdr_valid,
   input  logic                         hdr_first,
   input  logic                         hdr_last,
   input  logic [7:0]                   hdr_byte,
   output logic                         dec_valid,
   output logic                         dec_accept
);
   localparam int unsigned DEST_W = 8 * MAC_BYTES;
   localparam int unsigned LK_W   = $clog2(TBL_WORDS * WORD_W);

   initial begin
      top_geom_chk: assert (LK_W == HASH_W && HDR_BYTES == 16 && N_EXACT >= 1)
         else $error("rx_addr_filter: bitmaps must hold 4096 bits, header 16 bytes");
   end

   logic [DEST_W-1:0] dest;
   logic [15:0]       ethtype;
   logic [11:0]       vlan_id;
   logic              eval_go;
   logic              eval_full;

   rxf_hdr_capture #(.HDR_BYTES(HDR_BYTES), .TAG_POS(HDR_BYTES - 4)) u_cap (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (hdr_valid),
      .in_first  (hdr_first),
      .in_last   (hdr_last),
      .in_byte   (hdr_byte),
      .dest      (dest),
      .ethtype   (ethtype),
      .vlan_id   (vlan_id),
      .eval_go   (eval_go),
      .eval_full (eval_full)
   );

   logic              cam_hit;
   rxf_exact_cam #(.ENTRIES(N_EXACT), .ADDR_W(DEST_W)) u_cam (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (ent_we),
      .widx   (ent_idx),
      .waddr  (ent_mac),
      .wvalid (ent_valid),
      .dest   (dest),
      .hit    (cam_hit)
   );

   // table 0 is the multicast hash, table 1 the VLAN membership map
   logic [HASH_W-1:0] hash;
   logic [1:0]        tbl_bit;
   assign hash = hash_window({dest[47:40], dest[39:32]}, cfg_hash_sel);

   for (genvar t = 0; t < 2; t++) begin : g_tbl
      logic [LK_W-1:0] lk;
      assign lk = (t == 0) ? LK_W'(hash) : LK_W'(vlan_id);
      rxf_bit_table #(.WORDS(TBL_WORDS), .WORD_W(WORD_W)) u_tbl (
         .clk    (clk),
         .rst_n  (rst_n),
         .we     (tbl_we && (tbl_sel == 1'(t))),
         .widx   (tbl_idx),
         .wdata  (tbl_wdata),
         .lk_idx (lk),
         .lk_bit (tbl_bit[t])
      );
   end

   logic vlan_tagged;
   logic vlan_veto;
   logic is_group;
   logic is_bcast;
   logic accept_n;

   assign vlan_tagged = eval_full && cfg_vlan_filt_en && (ethtype == cfg_tag_type);
   assign vlan_veto   = vlan_tagged && !tbl_bit[1];
   assign is_group    = dest[0];
   assign is_bcast    = &dest;
   assign accept_n    = !vlan_veto &&
                        (cfg_ucast_promisc ||
                         (cfg_mcast_promisc && is_group) ||
                         (cfg_bcast_en && is_bcast) ||
                         cam_hit ||
                         tbl_bit[0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dec_valid  <= 1'b0;
         dec_accept <= 1'b0;
      end else begin
         dec_valid  <= eval_go;
         dec_accept <= eval_go && accept_n;
      end
   end

   // R2
   decision_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eval_go |=> dec_valid);
   // R2
   no_spurious_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !eval_go |=> !dec_valid && !dec_accept);
   // R3
   vlan_veto_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eval_go && vlan_veto) |=> !dec_accept);
   // R5
   promisc_accepts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eval_go && !vlan_veto && cfg_ucast_promisc) |=> dec_accept);
endmodule

// File: tb/rx_addr_filter_tb.sv
module rx_addr_filter_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_ucast_promisc = 0, cfg_mcast_promisc = 0, cfg_bcast_en = 0;
   logic        cfg_vlan_filt_en = 0;
   logic [15:0] cfg_tag_type = 16'h8100;
   logic [1:0]  cfg_hash_sel = 2'd0;
   logic        ent_we = 0, ent_valid = 0;
   logic [3:0]  ent_idx = '0;
   logic [47:0] ent_mac = '0;
   logic        tbl_we = 0, tbl_sel = 0;
   logic [6:0]  tbl_idx = '0;
   logic [31:0] tbl_wdata = '0;
   logic        hdr_valid = 0, hdr_first = 0, hdr_last = 0;
   logic [7:0]  hdr_byte = '0;
   logic        dec_valid, dec_accept;

   int checks = 0;
   int fails  = 0;
   bit finished = 0;
   logic [7:0] fr [20];

   always #5 clk = ~clk;

   rx_addr_filter dut_i (
      .clk(clk), .rst_n(rst_n),
      .cfg_ucast_promisc(cfg_ucast_promisc), .cfg_mcast_promisc(cfg_mcast_promisc),
      .cfg_bcast_en(cfg_bcast_en), .cfg_vlan_filt_en(cfg_vlan_filt_en),
      .cfg_tag_type(cfg_tag_type), .cfg_hash_sel(cfg_hash_sel),
      .ent_we(ent_we), .ent_idx(ent_idx), .ent_mac(ent_mac), .ent_valid(ent_valid),
      .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_idx(tbl_idx), .tbl_wdata(tbl_wdata),
      .hdr_valid(hdr_valid), .hdr_first(hdr_first), .hdr_last(hdr_last),
      .hdr_byte(hdr_byte), .dec_valid(dec_valid), .dec_accept(dec_accept)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic wr_tbl(input bit sel, input int idx, input logic [31:0] d);
      @(negedge clk);
      tbl_we = 1; tbl_sel = sel; tbl_idx = 7'(idx); tbl_wdata = d;
      @(negedge clk);
      tbl_we = 0;
   endtask

   task automatic wr_ent(input int idx, input logic [47:0] mac, input bit v);
      @(negedge clk);
      ent_we = 1; ent_idx = 4'(idx); ent_mac = mac; ent_valid = v;
      @(negedge clk);
      ent_we = 0;
   endtask

   task automatic new_frame(input logic [7:0] b0, b1, b2, b3, b4, b5);
      for (int i = 0; i < 20; i++) fr[i] = 8'(8'h60 + i);
      fr[0] = b0; fr[1] = b1; fr[2] = b2; fr[3] = b3; fr[4] = b4; fr[5] = b5;
      fr[12] = 8'h08; fr[13] = 8'h00;
   endtask

   function automatic logic [11:0] bhash(input logic [7:0] b4, b5, input int sel);
      logic [15:0] p;
      int sh;
      p  = {b5, b4};
      sh = (sel == 0) ? 4 : (sel == 1) ? 3 : (sel == 2) ? 2 : 0;
      return 12'((p >> sh) & 16'h0fff);
   endfunction

   task automatic run_frame(input int len, input bit exp, input string req);
      int d;
      int hit_c;
      bit acc;
      bit stray;
      d = (len < 16) ? len - 1 : 15;
      hit_c = -1; acc = 0; stray = 0;
      for (int c = 0; c < len + 4; c++) begin
         @(negedge clk);
         if (dec_valid) begin
            if (c == d + 2 && hit_c < 0) begin hit_c = c; acc = dec_accept; end
            else stray = 1;
         end else if (dec_accept) stray = 1;
         if (c < len) begin
            hdr_valid = 1; hdr_first = (c == 0); hdr_last = (c == len - 1); hdr_byte = fr[c];
         end else begin
            hdr_valid = 0; hdr_first = 0; hdr_last = 0; hdr_byte = '0;
         end
      end
      chk(hit_c == d + 2 && !stray, req, "decision pulse cycle", hit_c, d + 2);
      chk(acc == exp, req, "accept", acc, exp);
   endtask

   task automatic t_reset;
      chk(dec_valid == 0 && dec_accept == 0, "R1", "outputs after reset", dec_valid, 0);
      new_frame(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55);
      run_frame(16, 0, "R1");
   endtask

   task automatic t_latency;
      cfg_ucast_promisc = 1;
      new_frame(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55);
      run_frame(20, 1, "R2");
      cfg_ucast_promisc = 0;
   endtask

   task automatic t_ucast;
      cfg_ucast_promisc = 1;
      new_frame(8'h0a, 8'hbb, 8'hcc, 8'hdd, 8'hee, 8'h01);
      run_frame(16, 1, "R5");
      cfg_ucast_promisc = 0;
      run_frame(16, 0, "R5");
   endtask

   task automatic t_mcast;
      cfg_mcast_promisc = 1;
      new_frame(8'h01, 8'h00, 8'h5e, 8'h00, 8'h00, 8'h01);
      run_frame(16, 1, "R6");
      fr[0] = 8'h02;
      run_frame(16, 0, "R6");
      cfg_mcast_promisc = 0;
   endtask

   task automatic t_bcast;
      cfg_bcast_en = 1;
      new_frame(8'hff, 8'hff, 8'hff, 8'hff, 8'hff, 8'hff);
      run_frame(16, 1, "R7");
      fr[5] = 8'hfe;
      run_frame(16, 0, "R7");
      cfg_bcast_en = 0;
      fr[5] = 8'hff;
      run_frame(16, 0, "R7");
   endtask

   task automatic t_exact;
      wr_ent(5, 48'h665544332211, 1);
      new_frame(8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66);
      run_frame(16, 1, "R8");
      new_frame(8'h66, 8'h55, 8'h44, 8'h33, 8'h22, 8'h11);
      run_frame(16, 0, "R8");
      wr_ent(15, 48'h0c0b0a090807, 1);
      new_frame(8'h07, 8'h08, 8'h09, 8'h0a, 8'h0b, 8'h0c);
      run_frame(16, 1, "R8");
      wr_ent(15, 48'h0c0b0a090807, 0);
      run_frame(16, 0, "R9");
      wr_ent(5, 48'h665544332211, 0);
      new_frame(8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66);
      run_frame(16, 0, "R9");
   endtask

   task automatic t_hash;
      logic [11:0] h1;
      h1 = bhash(8'h34, 8'h12, 1);
      wr_tbl(0, int'(h1[11:5]), 32'(1) << h1[4:0]);
      new_frame(8'h01, 8'h00, 8'h5e, 8'h00, 8'h34, 8'h12);
      for (int s = 0; s < 4; s++) begin
         cfg_hash_sel = 2'(s);
         run_frame(16, (s == 1), "R10");
      end
      // R12: a VLAN-map bit at the window-0 hash position must not feed the hash
      begin
         logic [11:0] h0;
         h0 = bhash(8'h34, 8'h12, 0);
         wr_tbl(1, int'(h0[11:5]), 32'(1) << h0[4:0]);
         cfg_hash_sel = 2'd0;
         run_frame(16, 0, "R12");
         wr_tbl(1, int'(h0[11:5]), 32'h0);
      end
      wr_tbl(0, int'(h1[11:5]), 32'h0);
      cfg_hash_sel = 2'd1;
      run_frame(16, 0, "R10");
      cfg_hash_sel = 2'd0;
   endtask

   task automatic t_vlan;
      cfg_ucast_promisc = 1;
      cfg_vlan_filt_en  = 1;
      cfg_tag_type      = 16'h8100;
      new_frame(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55);
      fr[12] = 8'h81; fr[13] = 8'h00; fr[14] = 8'hea; fr[15] = 8'hbc; // ID 0xABC
      run_frame(16, 0, "R3");
      // R12: hash-map write at the ID position must not admit the tagged frame
      wr_tbl(0, 8'hab >> 1 == 0 ? 0 : 12'habc >> 5, 32'(1) << 5'h1c);
      run_frame(16, 0, "R12");
      wr_tbl(0, 12'habc >> 5, 32'h0);
      wr_tbl(1, 12'habc >> 5, 32'(1) << 5'h1c);
      run_frame(16, 1, "R4");
      wr_tbl(1, 12'habc >> 5, 32'h0);
      cfg_vlan_filt_en = 0;
      run_frame(16, 1, "R4");
      cfg_vlan_filt_en = 1;
      cfg_tag_type = 16'h88a8;
      run_frame(16, 1, "R4");
      cfg_tag_type = 16'h8100;
      // R11: short frames skip the veto even with a matching type field
      run_frame(14, 1, "R11");
      cfg_ucast_promisc = 0;
      cfg_mcast_promisc = 1;
      new_frame(8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
      run_frame(4, 1, "R11");
      cfg_mcast_promisc = 0;
      cfg_bcast_en = 1;
      new_frame(8'hff, 8'hff, 8'hff, 8'hff, 8'hff, 8'hff);
      run_frame(4, 0, "R11");
      cfg_bcast_en = 0;
      cfg_vlan_filt_en = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_latency();
      t_ucast();
      t_mcast();
      t_bcast();
      t_exact();
      t_hash();
      t_vlan();
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #1000000;
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule